// File: doc/BRIEF.md
# Burst-Capable Synchronous SRAM Core

This block is a single-port, 32-bit-wide synchronous memory with a burst address front end. There are two address strobes, a processor-side strobe and a controller-side strobe. When either one is accepted on a rising clock edge, the block captures the external address and samples three chip enables. The chip-enable result selects or deselects the device until the next accepted strobe. The two low address bits seed a 2-bit burst counter. On later cycles, an advance input steps that counter through the aligned group of four words while the upper address bits stay fixed.

Writes are driven by four byte-lane strobes. These come from a global write input, which forces all lanes on, or from a byte-write enable combined with one active-low select per lane. Read data is registered on the edge that presents the address. The output drive flag follows the output-enable pin without a clock. That flag is held off for the first read that follows a deselected period.

The array depth is set through the address width parameter, which keeps simulation cheap. The core is intended as a behavioural memory behind a bus controller that issues single and burst accesses.

Top module: `burst_sram_core`

## Requirements
- R1: While reset is applied, and after it is released with no strobe accepted, `dq_oe` is 0 and the device is deselected.
- R2: A selected load by `adsp_n` is a read. On that edge `dq_o` takes the word at `addr`, and it is observable until the next edge.
- R3: A load is accepted when `adsp_n` is low with `ce1_n` low, or when `adsc_n` is low. On a load, the device is selected only if `ce1_n`=0, `ce2`=1 and `ce3_n`=0; otherwise it is deselected and performs no access. Chip-enable changes on cycles without a load have no effect. A deselected device neither reads nor writes until a selecting load.
- R4: A selected load sets the burst counter to `addr[1:0]`. On a selected cycle without a load, `adv_n`=0 first increments the counter modulo 4 and then accesses the word in the same aligned group. With `adv_n`=1 the counter is held.
- R5: `adsp_n` is ignored whenever `ce1_n` is 1.
- R6: When `adsp_n` and `adsc_n` are both low and `ce1_n` is low, the `adsp_n` load wins, and the cycle is a read even if write enables are active.
- R7: On a selected write-capable cycle (an `adsc_n` load or a continuation), `gw_n`=0 writes all four bytes, whatever `bwe_n` and `bw_n` hold.
- R8: With `gw_n`=1, byte lane i (bit i of `bw_n`, lane i = `dq_i[8i+7:8i]`) is written only when `bwe_n`=0 and `bw_n[i]`=0. If no lane is enabled, the selected cycle is a read.
- R9: `dq_oe` is 1 only while `oe_n` is 0, and it follows `oe_n` without waiting for a clock edge.
- R10: The first read after a deselected state leaves `dq_oe` at 0 for that clock. The next read in the same selected run drives.
- R11: After a write cycle, `dq_oe` is 0 until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Word address, captured on a load |
| adsp_n | input | 1 | Processor-side address strobe, active low, gated by `ce1_n` |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low, sampled on loads |
| ce2 | input | 1 | Chip enable, active high, sampled on loads |
| ce3_n | input | 1 | Chip enable, active low, sampled on loads |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane byte selects, active low, bit i = lane i |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 32 | Write data |
| dq_o | output | 32 | Registered read data |
| dq_oe | output | 1 | Data bus drive enable (1 = drive `dq_o`) |

## Verification
The assertions assume that `rst_n` is low from time zero and is held for several clocks. They also assume that every input is stable around each rising edge, with `oe_n` as the only input allowed to move at any time. The bench changes its inputs one nanosecond before each rising edge and samples half a period after it. It reads only addresses it has already written, so no check meets an uninitialised word. Bursts are started only by a selecting load, which keeps every counter step inside a known aligned group.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/bsram_lanes.sv
`timescale 1ns/1ps
module bsram_lanes
  import bsram_pkg::*;
(
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_we,
  output logic             wr_any
);
  always_comb begin
    if (!gw_n)       lane_we = '1;
    else if (!bwe_n) lane_we = ~bw_n;
    else             lane_we = '0;
    wr_any = |lane_we;
  end
endmodule

// File: rtl/bsram_ctrl.sv
`timescale 1ns/1ps
module bsram_ctrl
  import bsram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adsp_n,
  input  logic adsc_n,
  input  logic adv_n,
  input  logic ce1_n,
  input  logic ce2,
  input  logic ce3_n,
  input  logic wr_any,
  input  logic oe_n,
  output logic load_en,
  output logic step_en,
  output cyc_e cyc,
  output logic sel_q,
  output logic dq_oe
);
  logic ld_p, ld_any, sel_now, sel_d;
  logic rd_d, mask_d, rd_q, mask_q;

  // next-state decode
  always_comb begin
    ld_p    = !adsp_n && !ce1_n;
    ld_any  = ld_p || !adsc_n;
    sel_now = !ce1_n && ce2 && !ce3_n;
    sel_d   = ld_any ? sel_now : sel_q;
    load_en = ld_any && sel_now;
    step_en = !ld_any && sel_q && !adv_n;
    if (!sel_d)      cyc = CYC_NONE;
    else if (ld_p)   cyc = CYC_READ;
    else if (wr_any) cyc = CYC_WRITE;
    else             cyc = CYC_READ;
    rd_d   = (cyc == CYC_READ);
    mask_d = rd_d && !sel_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      rd_q   <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      rd_q   <= rd_d;
      mask_q <= mask_d;
    end
  end

  assign dq_oe = rd_q && !mask_q && !oe_n;
endmodule

// File: rtl/bsram_burst.sv
`timescale 1ns/1ps
module bsram_burst #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              load_en,
  input  logic              step_en,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [1:0]        cnt_q
);
  localparam int BASE_W = ADDR_W - 2;

  logic [BASE_W-1:0] base_q, base_d;
  logic [1:0]        cnt_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load_en) begin
      base_d = addr[ADDR_W-1:2];
      cnt_d  = addr[1:0];
    end else if (step_en) begin
      cnt_d  = cnt_q + 2'd1;
    end
    acc_addr = {base_d, cnt_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_en || step_en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/bsram_array.sv
`timescale 1ns/1ps
module bsram_array
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [LANES-1:0]  lane_we,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && lane_we[g]) mem[acc_addr] <= din[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= mem[acc_addr];
    end

    assign dout[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/burst_sram_core.sv
`timescale 1ns/1ps
module burst_sram_core
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [3:0]        bw_n,
  input  logic              oe_n,
  input  logic [31:0]       dq_i,
  output logic [31:0]       dq_o,
  output logic              dq_oe
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [LANES-1:0]  lane_we;
  logic              wr_any, load_en, step_en, sel_q;
  cyc_e              cyc;
  logic [ADDR_W-1:0] acc_addr;
  logic [1:0]        cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  bsram_lanes u_lanes (
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .lane_we(lane_we), .wr_any(wr_any)
  );

  bsram_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .wr_any(wr_any), .oe_n(oe_n),
    .load_en(load_en), .step_en(step_en), .cyc(cyc),
    .sel_q(sel_q), .dq_oe(dq_oe)
  );

  bsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_int_n), .addr(addr),
    .load_en(load_en), .step_en(step_en),
    .acc_addr(acc_addr), .cnt_q(cnt_q)
  );

  bsram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_int_n), .acc_addr(acc_addr),
    .wr_en(cyc == CYC_WRITE), .rd_en(cyc == CYC_READ),
    .lane_we(lane_we), .din(dq_i), .dout(dq_o)
  );
endmodule

// File: rtl/bsram_checker.sv
`timescale 1ns/1ps
module bsram_checker
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              load_en,
  input logic              step_en,
  input logic              sel_q,
  input cyc_e              cyc,
  input logic [1:0]        cnt_q
);
  a_r9_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !oe_n);

  a_r3_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (((!adsp_n && !ce1_n) || !adsc_n) && (ce1_n || !ce2 || ce3_n)) |=> !dq_oe);

  a_r2_load_bits: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt_q == $past(addr[1:0])));

  a_r4_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (cnt_q == $past(cnt_q) + 2'd1));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> $stable(cnt_q));

  a_r5_adsp_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && ce1_n && adsc_n) |-> !load_en);

  a_r6_adsp_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !adsc_n && !ce1_n && ce2 && !ce3_n) |-> (cyc == CYC_READ));

  a_r10_first_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> !dq_oe);

  a_r11_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_WRITE) |=> !dq_oe);
endmodule

bind burst_sram_core bsram_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .addr(addr),
  .adsp_n(adsp_n), .adsc_n(adsc_n),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .oe_n(oe_n), .dq_oe(dq_oe),
  .load_en(load_en), .step_en(step_en), .sel_q(sel_q),
  .cyc(cyc), .cnt_q(cnt_q)
);

// File: tb/sim_burst_sram_core.sv
`timescale 1ns/1ps
module sim_burst_sram_core;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n;
  logic [3:0]    bw_n;
  logic [31:0]   dq_i, dq_o;
  logic          dq_oe;

  always #2 clk = ~clk;

  burst_sram_core #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  typedef struct {
    logic        en;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 0;

  logic [31:0]   mm [1 << AW];
  logic          m_sel;
  logic [AW-3:0] m_base;
  logic [1:0]    m_cnt;

  // monitor: pops one expected item per cycle, half a period after the edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      logic een;
      e   = sb.pop_front();
      een = e.en && !oe_n;
      n_cmp++;
      if (dq_oe !== een) begin
        n_bad++;
        $display("FAIL %s: dq_oe=%0b expected %0b", e.tag, dq_oe, een);
      end else if (een && dq_o !== e.data) begin
        n_bad++;
        $display("FAIL %s: dq_o=%h expected %h", e.tag, dq_o, e.data);
      end
    end
  end

  task automatic step(input logic [AW-1:0] a, input logic p_n, input logic c_n,
                      input logic v_n, input logic e1_n, input logic e2,
                      input logic e3_n, input logic g_n, input logic be_n,
                      input logic [3:0] b_n, input logic [31:0] d,
                      input logic o_n, input string tag);
    logic ldp, ld, snow, snext;
    logic [3:0] we;
    logic [AW-1:0] acc;
    exp_t e;
    @(negedge clk);
    #1;
    addr = a; adsp_n = p_n; adsc_n = c_n; adv_n = v_n;
    ce1_n = e1_n; ce2 = e2; ce3_n = e3_n;
    gw_n = g_n; bwe_n = be_n; bw_n = b_n; dq_i = d; oe_n = o_n;
    @(posedge clk);
    // reference model from the requirements
    ldp   = !p_n && !e1_n;
    ld    = ldp || !c_n;
    snow  = !e1_n && e2 && !e3_n;
    snext = ld ? snow : m_sel;
    we    = !g_n ? 4'hF : (!be_n ? ~b_n : 4'h0);
    if (ld && snow) begin
      m_base = a[AW-1:2];
      m_cnt  = a[1:0];
    end else if (!ld && m_sel && !v_n) begin
      m_cnt = m_cnt + 2'd1;
    end
    acc    = {m_base, m_cnt};
    e.en   = 1'b0;
    e.data = '0;
    e.tag  = tag;
    if (snext) begin
      if (!ldp && we != 4'h0) begin
        for (int i = 0; i < 4; i++)
          if (we[i]) mm[acc][i*8 +: 8] = d[i*8 +: 8];
      end else begin
        e.en   = m_sel;
        e.data = mm[acc];
      end
    end
    m_sel = snext;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step('0, 1, 1, 1, 1, 0, 1, 1, 1, 4'hF, '0, 0, tag);
  endtask

  initial begin
    #80000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; addr = '0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    ce1_n = 1; ce2 = 0; ce3_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
    dq_i = '0; oe_n = 0;
    m_sel = 0; m_base = '0; m_cnt = '0;
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (dq_oe !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset: dq_oe=%0b expected 0", dq_oe);
    end
    rst_n = 1;
    repeat (3) idle("R1 idle after reset");

    // writes: global and per-lane
    step(8'h10, 1, 0, 1, 0, 1, 0, 0, 1, 4'hF, 32'hA5A5_0001, 0, "R7 global write");
    step(8'h10, 1, 1, 1, 0, 1, 0, 1, 0, 4'b1110, 32'h1122_3344, 0, "R8 lane0 write");
    step(8'h10, 1, 1, 1, 0, 1, 0, 1, 1, 4'hF, '0, 0, "R8 read after lane write");
    step(8'h10, 1, 1, 1, 0, 1, 0, 1, 1, 4'h0, 32'hFFFF_FFFF, 0, "R8 selects without bwe");

    // burst of writes with wrap
    step(8'h22, 1, 0, 1, 0, 1, 0, 0, 1, 4'hF, 32'h0A0B_0C0D, 0, "R11 burst write 0");
    step(8'h00, 1, 1, 0, 0, 1, 0, 0, 1, 4'hF, 32'h1A1B_1C1D, 0, "R4 burst write 1");
    step(8'h00, 1, 1, 0, 0, 1, 0, 0, 1, 4'hF, 32'h2A2B_2C2D, 0, "R4 burst write wrap");
    step(8'h00, 1, 1, 0, 0, 1, 0, 0, 1, 4'hF, 32'h3A3B_3C3D, 0, "R4 burst write 3");

    // processor-side burst read, priority over controller strobe
    step(8'h22, 0, 0, 1, 0, 1, 0, 0, 1, 4'hF, 32'h0BAD_0BAD, 0, "R6 R2 adsp read wins");
    step(8'h00, 1, 1, 0, 0, 1, 0, 1, 1, 4'hF, '0, 0, "R4 advance read");
    step(8'h00, 1, 1, 0, 0, 1, 0, 1, 1, 4'hF, '0, 0, "R4 advance wrap read");
    step(8'h00, 1, 1, 1, 0, 1, 0, 1, 1, 4'hF, '0, 0, "R4 hold without advance");
    step(8'h10, 0, 1, 1, 1, 1, 0, 1, 1, 4'hF, '0, 0, "R5 adsp ignored ce1 high");
    step(8'h10, 1, 1, 1, 0, 0, 0, 1, 1, 4'hF, '0, 0, "R3 ce ignored without load");

    // deselect and ignored activity
    step(8'h10, 1, 0, 1, 0, 0, 0, 1, 1, 4'hF, '0, 0, "R3 deselecting load");
    step(8'h20, 1, 1, 0, 0, 1, 0, 0, 1, 4'hF, 32'hDEAD_DEAD, 0, "R3 deselected write ignored");

    // first read after deselect is masked
    step(8'h10, 0, 1, 1, 0, 1, 0, 1, 1, 4'hF, '0, 0, "R10 first read masked");
    step(8'h10, 1, 1, 1, 0, 1, 0, 1, 1, 4'hF, '0, 0, "R10 second read drives");
    step(8'h10, 1, 1, 1, 0, 1, 0, 1, 1, 4'hF, '0, 1, "R9 oe high no drive");
    step(8'h21, 1, 0, 1, 0, 1, 0, 1, 1, 4'hF, '0, 0, "R3 word 0x21 intact");
    step(8'h20, 1, 0, 1, 0, 1, 0, 1, 1, 4'hF, '0, 0, "R3 word 0x20 intact");

    // mixed lanes
    step(8'h20, 1, 0, 1, 0, 1, 0, 1, 0, 4'b0101, 32'hFFFF_FFFF, 0, "R8 lanes 1 and 3");
    step(8'h20, 1, 1, 1, 0, 1, 0, 1, 1, 4'hF, '0, 0, "R8 mixed lane result");
    step(8'h20, 1, 1, 1, 0, 1, 0, 1, 1, 4'hF, '0, 1, "R9 oe high again");
    idle("R11 tail");
    @(negedge clk);
    @(negedge clk);

    // R9: the drive flag follows oe_n between edges
    step(8'h20, 1, 1, 1, 0, 1, 0, 1, 1, 4'hF, '0, 0, "R9 read for async check");
    @(negedge clk);
    #0.5;
    oe_n = 1;
    #0.2;
    n_cmp++;
    if (dq_oe !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 async: dq_oe=%0b expected 0", dq_oe);
    end
    oe_n = 0;
    #0.2;
    n_cmp++;
    if (dq_oe !== 1'b1) begin
      n_bad++;
      $display("FAIL R9 async: dq_oe=%0b expected 1", dq_oe);
    end

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule